// File: doc/BRIEF.md
# Hashed Inverted Page Table Lookup

This block translates a (process id, virtual page) pair into a physical page number by searching an inverted page table. The table holds one entry per physical frame, and each entry records which process and which virtual page currently own that frame. The physical page number is not stored anywhere. It is the position of the matching entry, and the block joins it with the page offset of the request to form the physical address. The table lives in on-chip registers.

A linear search would compare the key against every entry. This block instead folds the virtual page and the process id into a bucket number. A small anchor array maps each bucket to the first entry of its collision chain, and each entry carries a link to the next entry of the same chain. The walker compares one entry per clock cycle and follows the links. It answers with a hit when an entry matches. It answers with a miss when the chain ends, or when it has made as many probes as there are frames. That limit stops a corrupted, circular chain from hanging the lookup.

A host fills the table through a write port. One kind of write sets an entry, and the other sets a bucket anchor. Handling a miss is left to the surrounding system.

Top module: `ipt_lookup`

## Requirements
- R1: After reset every entry is invalid, every anchor holds the null link, `req_ready` is 1 and `rsp_valid` is 0, so any lookup misses.
- R2: The start bucket has BW = log2(BUCKETS) bits. Bucket bit b is the XOR of every virtual page bit and every process id bit whose bit position modulo BW equals b. The first entry probed is the one named by that bucket's anchor.
- R3: On a hit, `rsp_frame` is the index of the matching entry and `rsp_paddr` is that index placed above the request's page offset, i.e. {frame, offset}.
- R4: An entry matches only when its valid bit is 1, its process id equals the request's and its virtual page equals the request's. A non-matching entry, including an invalid one, is passed over through its link.
- R5: The block examines one entry per cycle. If the request is accepted at clock edge 0 and the k-th entry probed matches, the response appears after edge k.
- R6: Links are FW+1 bits wide, with FW = log2(FRAMES). A link whose top bit is 1 is null and ends the chain. A chain of L non-matching entries gives a miss after edge L+1, and an empty bucket gives a miss after edge 1.
- R7: After FRAMES probes without a match, the block reports a miss whatever the last link holds. A circular chain therefore gives a miss after edge FRAMES.
- R8: `req_ready` is 0 from acceptance until the response. A request presented while `req_ready` is 0 is ignored and produces no response.
- R9: With `wr_en` = 1 and `wr_anchor` = 0, entry `wr_idx` takes `wr_valid`, `wr_pid`, `wr_vpn` and `wr_link` as its valid bit, process id, virtual page and next link. With `wr_anchor` = 1, bucket `wr_idx[BW-1:0]` takes `wr_link` as its head. Later lookups see the new contents.
- R10: `rsp_valid` is a single-cycle pulse. While it is high exactly one of `rsp_hit` and `rsp_miss` is 1, and both are 0 while it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Lookup request strobe |
| req_ready | output | 1 | Walker idle, request accepted when both high |
| req_pid | input | PID_W | Process id of the request |
| req_vpn | input | VPN_W | Virtual page number of the request |
| req_off | input | OFF_W | Page offset of the request |
| rsp_valid | output | 1 | Response pulse |
| rsp_hit | output | 1 | Translation found |
| rsp_miss | output | 1 | Miss flag: chain ended or probe limit reached |
| rsp_frame | output | FW | Matching frame index |
| rsp_paddr | output | FW+OFF_W | Physical address {frame, offset}, zero on a miss |
| wr_en | input | 1 | Table write strobe |
| wr_anchor | input | 1 | 1 writes a bucket anchor, 0 writes an entry |
| wr_idx | input | FW | Entry index, or bucket number in the low BW bits |
| wr_valid | input | 1 | Valid bit for an entry write |
| wr_pid | input | PID_W | Process id for an entry write |
| wr_vpn | input | VPN_W | Virtual page for an entry write |
| wr_link | input | FW+1 | Next link (entry) or chain head (anchor); top bit 1 means null |

## Verification
Assertions check the response rules on every cycle: the single-cycle pulse with exactly one of hit or miss, `req_ready` low during a walk, the probe counter staying below the frame count, and an entry write landing in the addressed entry. The directed scenarios are the only way to show the bucket arithmetic, the matching rules for process id, valid bit and virtual page, and the cycle at which each response arrives. The scenarios include chain positions, empty buckets, invalid links inside a chain, a circular chain and requests presented while the walker is busy.

// File: rtl/ipt_pkg.sv
package ipt_pkg;
  typedef enum logic {
    WK_IDLE = 1'b0,
    WK_WALK = 1'b1
  } walk_state_t;
endpackage

// File: rtl/ipt_store.sv
module ipt_store #(
  parameter int FRAMES  = 16,
  parameter int BUCKETS = 8,
  parameter int PID_W   = 4,
  parameter int VPN_W   = 12,
  localparam int FW = $clog2(FRAMES),
  localparam int BW = $clog2(BUCKETS),
  localparam int NW = FW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_anchor,
  input  logic [FW-1:0]    wr_idx,
  input  logic             wr_valid,
  input  logic [PID_W-1:0] wr_pid,
  input  logic [VPN_W-1:0] wr_vpn,
  input  logic [NW-1:0]    wr_link,
  input  logic [BW-1:0]    head_bucket,
  output logic [NW-1:0]    head_link,
  input  logic [FW-1:0]    rd_idx,
  output logic             rd_valid,
  output logic [PID_W-1:0] rd_pid,
  output logic [VPN_W-1:0] rd_vpn,
  output logic [NW-1:0]    rd_next
);
  localparam logic [NW-1:0] NULL_LINK = {1'b1, {FW{1'b0}}};

  logic             ent_valid_q [FRAMES];
  logic [PID_W-1:0] ent_pid_q   [FRAMES];
  logic [VPN_W-1:0] ent_vpn_q   [FRAMES];
  logic [NW-1:0]    ent_next_q  [FRAMES];
  logic [NW-1:0]    anchor_q    [BUCKETS];

  logic entry_wr;
  logic anchor_wr;
  assign entry_wr  = wr_en && !wr_anchor;
  assign anchor_wr = wr_en && wr_anchor;

  for (genvar f = 0; f < FRAMES; f++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_valid_q[f] <= 1'b0;
        ent_pid_q[f]   <= '0;
        ent_vpn_q[f]   <= '0;
        ent_next_q[f]  <= NULL_LINK;
      end else if (entry_wr && wr_idx == FW'(f)) begin
        ent_valid_q[f] <= wr_valid;
        ent_pid_q[f]   <= wr_pid;
        ent_vpn_q[f]   <= wr_vpn;
        ent_next_q[f]  <= wr_link;
      end
    end
  end

  for (genvar b = 0; b < BUCKETS; b++) begin : g_anchor
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        anchor_q[b] <= NULL_LINK;
      end else if (anchor_wr && wr_idx[BW-1:0] == BW'(b)) begin
        anchor_q[b] <= wr_link;
      end
    end
  end

  assign head_link = anchor_q[head_bucket];
  assign rd_valid  = ent_valid_q[rd_idx];
  assign rd_pid    = ent_pid_q[rd_idx];
  assign rd_vpn    = ent_vpn_q[rd_idx];
  assign rd_next   = ent_next_q[rd_idx];

  // R9: an entry write lands in the addressed entry
  p_entry_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    entry_wr |=> (ent_pid_q[$past(wr_idx)] == $past(wr_pid)) &&
                 (ent_vpn_q[$past(wr_idx)] == $past(wr_vpn)) &&
                 (ent_next_q[$past(wr_idx)] == $past(wr_link)));

  // R9: an anchor write lands in the addressed bucket
  p_anchor_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    anchor_wr |=> anchor_q[$past(wr_idx[BW-1:0])] == $past(wr_link));
endmodule

// File: rtl/ipt_walker.sv
module ipt_walker
  import ipt_pkg::*;
#(
  parameter int FRAMES  = 16,
  parameter int BUCKETS = 8,
  parameter int PID_W   = 4,
  parameter int VPN_W   = 12,
  parameter int OFF_W   = 12,
  localparam int FW = $clog2(FRAMES),
  localparam int BW = $clog2(BUCKETS),
  localparam int NW = FW + 1,
  localparam int SW = FW + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [PID_W-1:0]    req_pid,
  input  logic [VPN_W-1:0]    req_vpn,
  input  logic [OFF_W-1:0]    req_off,
  output logic [BW-1:0]       head_bucket,
  input  logic [NW-1:0]       head_link,
  output logic [FW-1:0]       probe_idx,
  input  logic                ent_valid,
  input  logic [PID_W-1:0]    ent_pid,
  input  logic [VPN_W-1:0]    ent_vpn,
  input  logic [NW-1:0]       ent_next,
  output logic                rsp_valid,
  output logic                rsp_hit,
  output logic                rsp_miss,
  output logic [FW-1:0]       rsp_frame,
  output logic [FW+OFF_W-1:0] rsp_paddr
);
  // XOR-fold of page and process id into a bucket number
  function automatic logic [BW-1:0] fold_hash(input logic [VPN_W-1:0] v,
                                              input logic [PID_W-1:0] p);
    logic [BW-1:0] h;
    h = '0;
    for (int i = 0; i < VPN_W; i += BW) h = h ^ BW'(v >> i);
    for (int i = 0; i < PID_W; i += BW) h = h ^ BW'(p >> i);
    return h;
  endfunction

  function automatic logic key_match(input logic v, input logic [PID_W-1:0] ep,
                                     input logic [VPN_W-1:0] ev,
                                     input logic [PID_W-1:0] kp,
                                     input logic [VPN_W-1:0] kv);
    return v && (ep == kp) && (ev == kv);
  endfunction

  walk_state_t      state_q;
  logic [PID_W-1:0] key_pid_q;
  logic [VPN_W-1:0] key_vpn_q;
  logic [OFF_W-1:0] key_off_q;
  logic [NW-1:0]    cur_q;
  logic [SW-1:0]    steps_q;

  // named internal events
  logic walking, accept, chain_end, probe_hit, limit_hit, step_on;
  assign walking   = (state_q == WK_WALK);
  assign req_ready = !walking;
  assign accept    = req_valid && req_ready;
  assign chain_end = walking && cur_q[NW-1];
  assign probe_hit = walking && !cur_q[NW-1] &&
                     key_match(ent_valid, ent_pid, ent_vpn, key_pid_q, key_vpn_q);
  assign limit_hit = walking && !chain_end && !probe_hit &&
                     (steps_q == SW'(FRAMES - 1));
  assign step_on   = walking && !chain_end && !probe_hit && !limit_hit;

  assign head_bucket = fold_hash(req_vpn, req_pid);
  assign probe_idx   = cur_q[FW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= WK_IDLE;
      key_pid_q <= '0;
      key_vpn_q <= '0;
      key_off_q <= '0;
      cur_q     <= '0;
      steps_q   <= '0;
    end else if (accept) begin
      state_q   <= WK_WALK;
      key_pid_q <= req_pid;
      key_vpn_q <= req_vpn;
      key_off_q <= req_off;
      cur_q     <= head_link;
      steps_q   <= '0;
    end else if (step_on) begin
      cur_q   <= ent_next;
      steps_q <= steps_q + SW'(1);
    end else if (chain_end || probe_hit || limit_hit) begin
      state_q <= WK_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_frame <= '0;
      rsp_paddr <= '0;
    end else begin
      rsp_valid <= chain_end || probe_hit || limit_hit;
      rsp_hit   <= probe_hit;
      rsp_miss  <= chain_end || limit_hit;
      rsp_frame <= probe_hit ? cur_q[FW-1:0] : '0;
      rsp_paddr <= probe_hit ? {cur_q[FW-1:0], key_off_q} : '0;
    end
  end

  // R10: exactly one outcome while a response is shown, none otherwise
  p_one_outcome_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid ? $onehot({rsp_hit, rsp_miss}) : !(rsp_hit || rsp_miss));

  // R10: response is a single-cycle pulse
  p_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R8: no acceptance while a walk is in progress
  p_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(accept) |-> !req_ready || rsp_valid);

  // R7: the probe counter never reaches the frame count
  p_limit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    walking |-> steps_q < SW'(FRAMES));

  // R3: a hit response places the frame above the captured offset
  p_paddr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    probe_hit |=> rsp_paddr[FW+OFF_W-1:OFF_W] == rsp_frame);
endmodule

// File: rtl/ipt_lookup.sv
module ipt_lookup #(
  parameter int FRAMES  = 16,
  parameter int BUCKETS = 8,
  parameter int PID_W   = 4,
  parameter int VPN_W   = 12,
  parameter int OFF_W   = 12,
  localparam int FW = $clog2(FRAMES),
  localparam int BW = $clog2(BUCKETS),
  localparam int NW = FW + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [PID_W-1:0]    req_pid,
  input  logic [VPN_W-1:0]    req_vpn,
  input  logic [OFF_W-1:0]    req_off,
  output logic                rsp_valid,
  output logic                rsp_hit,
  output logic                rsp_miss,
  output logic [FW-1:0]       rsp_frame,
  output logic [FW+OFF_W-1:0] rsp_paddr,
  input  logic                wr_en,
  input  logic                wr_anchor,
  input  logic [FW-1:0]       wr_idx,
  input  logic                wr_valid,
  input  logic [PID_W-1:0]    wr_pid,
  input  logic [VPN_W-1:0]    wr_vpn,
  input  logic [NW-1:0]       wr_link
);
  logic [BW-1:0]    head_bucket;
  logic [NW-1:0]    head_link;
  logic [FW-1:0]    probe_idx;
  logic             ent_valid;
  logic [PID_W-1:0] ent_pid;
  logic [VPN_W-1:0] ent_vpn;
  logic [NW-1:0]    ent_next;

  ipt_store #(
    .FRAMES(FRAMES), .BUCKETS(BUCKETS), .PID_W(PID_W), .VPN_W(VPN_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_anchor(wr_anchor), .wr_idx(wr_idx),
    .wr_valid(wr_valid), .wr_pid(wr_pid), .wr_vpn(wr_vpn), .wr_link(wr_link),
    .head_bucket(head_bucket), .head_link(head_link),
    .rd_idx(probe_idx), .rd_valid(ent_valid), .rd_pid(ent_pid),
    .rd_vpn(ent_vpn), .rd_next(ent_next)
  );

  ipt_walker #(
    .FRAMES(FRAMES), .BUCKETS(BUCKETS), .PID_W(PID_W), .VPN_W(VPN_W),
    .OFF_W(OFF_W)
  ) u_walker (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_pid(req_pid), .req_vpn(req_vpn), .req_off(req_off),
    .head_bucket(head_bucket), .head_link(head_link),
    .probe_idx(probe_idx), .ent_valid(ent_valid), .ent_pid(ent_pid),
    .ent_vpn(ent_vpn), .ent_next(ent_next),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
    .rsp_frame(rsp_frame), .rsp_paddr(rsp_paddr)
  );
endmodule

// File: tb/tb_ipt_lookup.sv
`timescale 1ns/1ps
module tb_ipt_lookup;
  localparam int FRAMES = 16, BUCKETS = 8, PID_W = 4, VPN_W = 12, OFF_W = 12;
  localparam int FW = 4, BW = 3, NW = 5;
  localparam logic [NW-1:0] NUL = 5'h10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, wr_en = 0, wr_anchor = 0, wr_valid = 0;
  logic [PID_W-1:0] req_pid = '0, wr_pid = '0;
  logic [VPN_W-1:0] req_vpn = '0, wr_vpn = '0;
  logic [OFF_W-1:0] req_off = '0;
  logic [FW-1:0] wr_idx = '0;
  logic [NW-1:0] wr_link = '0;
  logic req_ready, rsp_valid, rsp_hit, rsp_miss;
  logic [FW-1:0] rsp_frame;
  logic [FW+OFF_W-1:0] rsp_paddr;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ipt_lookup #(.FRAMES(FRAMES), .BUCKETS(BUCKETS), .PID_W(PID_W),
               .VPN_W(VPN_W), .OFF_W(OFF_W)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_pid(req_pid), .req_vpn(req_vpn), .req_off(req_off),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
    .rsp_frame(rsp_frame), .rsp_paddr(rsp_paddr),
    .wr_en(wr_en), .wr_anchor(wr_anchor), .wr_idx(wr_idx), .wr_valid(wr_valid),
    .wr_pid(wr_pid), .wr_vpn(wr_vpn), .wr_link(wr_link));

  task automatic check(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // bucket: bit b collects every key bit whose position mod BW is b
  function automatic logic [BW-1:0] bucket_of(logic [PID_W-1:0] p,
                                              logic [VPN_W-1:0] v);
    logic [BW-1:0] h = '0;
    for (int i = 0; i < VPN_W; i++) h[i % BW] ^= v[i];
    for (int i = 0; i < PID_W; i++) h[i % BW] ^= p[i];
    return h;
  endfunction

  task automatic put_entry(int idx, bit v, int p, int vp, logic [NW-1:0] nx);
    @(negedge clk);
    wr_en = 1; wr_anchor = 0; wr_idx = FW'(idx); wr_valid = v;
    wr_pid = PID_W'(p); wr_vpn = VPN_W'(vp); wr_link = nx;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic put_anchor(logic [BW-1:0] b, logic [NW-1:0] head);
    @(negedge clk);
    wr_en = 1; wr_anchor = 1; wr_idx = FW'(b); wr_link = head;
    @(negedge clk);
    wr_en = 0; wr_anchor = 0;
  endtask

  // issue one lookup and check outcome, frame, address and latency
  task automatic lookup(string tag, int p, int vp, int off,
                        bit exp_hit, int exp_frame, int exp_lat);
    int lat = 0;
    @(negedge clk);
    check({tag, " ready before request"}, req_ready, 1);
    req_valid = 1; req_pid = PID_W'(p); req_vpn = VPN_W'(vp); req_off = OFF_W'(off);
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    while (!rsp_valid && lat < 40) begin
      @(posedge clk); lat++;
      @(negedge clk);
    end
    check({tag, " latency"}, lat, exp_lat);
    check({tag, " hit"}, rsp_hit, exp_hit);
    check({tag, " miss"}, rsp_miss, !exp_hit);
    if (exp_hit) begin
      check({tag, " frame"}, rsp_frame, exp_frame);
      check({tag, " paddr"}, rsp_paddr, (exp_frame << OFF_W) | off);
    end
    @(negedge clk);
    check({tag, " R10 pulse ends"}, rsp_valid, 0);
  endtask

  task automatic t_reset();
    check("R1 ready after reset", req_ready, 1);
    check("R1 no response after reset", rsp_valid, 0);
    lookup("R1 R6 empty table miss", 3, 'h0A5, 'h123, 0, 0, 1);
  endtask

  task automatic t_chain();
    logic [BW-1:0] b = bucket_of(5, 'h100);
    check("R2 collision keys share bucket", bucket_of(5, 'h124), b);
    put_entry(5, 1, 5, 'h100, 5'd9);
    put_entry(9, 1, 5, 'h109, 5'd2);
    put_entry(2, 1, 5, 'h112, NUL);
    put_anchor(b, 5'd5);
    lookup("R2 R3 R5 head hit", 5, 'h100, 'hABC, 1, 5, 1);
    lookup("R5 second in chain", 5, 'h109, 'h001, 1, 9, 2);
    lookup("R3 R5 third in chain", 5, 'h112, 'hFFF, 1, 2, 3);
    lookup("R6 chain end miss", 5, 'h124, 'h000, 0, 0, 4);
  endtask

  task automatic t_match_rules();
    logic [BW-1:0] b = bucket_of(2, 'h055);
    put_entry(7, 1, 1, 'h055, 5'd8);   // other process
    put_entry(8, 0, 2, 'h055, 5'd10);  // invalid copy
    put_entry(10, 1, 2, 'h055, NUL);
    put_anchor(b, 5'd7);
    lookup("R4 skip pid mismatch and invalid", 2, 'h055, 'h777, 1, 10, 3);
    put_entry(10, 0, 2, 'h055, NUL);
    lookup("R9 R4 invalidated entry misses", 2, 'h055, 'h777, 0, 0, 4);
    put_anchor(b, NUL);
    lookup("R9 R6 null anchor misses", 2, 'h055, 'h777, 0, 0, 1);
  endtask

  task automatic t_loop();
    logic [BW-1:0] b = bucket_of(7, 'h3C3);
    put_entry(3, 1, 0, 'h000, 5'd4);
    put_entry(4, 1, 0, 'h000, 5'd3);
    put_anchor(b, 5'd3);
    lookup("R7 circular chain limit", 7, 'h3C3, 'h010, 0, 0, FRAMES);
  endtask

  task automatic t_busy();
    int resp = 0;
    logic last_hit = 0;
    @(negedge clk);
    req_valid = 1; req_pid = 7; req_vpn = 'h3C3; req_off = 0;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    @(negedge clk);
    check("R8 ready low while walking", req_ready, 0);
    req_valid = 1; req_pid = 5; req_vpn = 'h100;  // would hit if taken
    @(negedge clk);
    req_valid = 0;
    for (int c = 0; c < 30; c++) begin
      @(negedge clk);
      if (rsp_valid) begin resp++; last_hit = rsp_hit; end
    end
    check("R8 busy request ignored, one response", resp, 1);
    check("R8 the response is the walked miss", last_hit, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_chain();
    t_match_rules();
    t_loop();
    t_busy();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule